// File: doc/BRIEF.md
# Event Timer/Counter with Shared Prescaler

This block is an 8-bit up-counter that software can load at any time and read continuously. In timer mode it advances on instruction-cycle ticks. An instruction-cycle tick is a one-clock enable supplied by the surrounding core, once every four system clocks. In counter mode it advances on qualified edges of an external event source. That source is either an input pin or the output of an on-chip comparator. Three routing bits choose between them. The chosen source is sampled on instruction ticks through a two-stage synchronizer. A one-tick edge detector then follows, and its polarity is programmable.

A single prescaler sits between the qualified events and the counter. One control bit hands it either to the counter or to an external watchdog, never to both. When the counter owns it, a 3-bit field picks a ratio of 2 raised to (field + 1), from 1:2 to 1:256. When the watchdog owns it, the prescaler divides the watchdog's base tick instead, and the counter takes every qualified event undivided. A software load clears the hidden prescaler count. The load also holds the counter still for the next two instruction ticks. Wrapping from 0xFF to 0x00 raises a one-clock overflow pulse.

Top module: `evt_timer`

## Requirements
- R1: After reset, count_o is 0x00 and ovf_o is 0.
- R2: When wr_en_i is high at a clock edge, count_o equals wr_data_i from that edge on. A load takes priority over any increment at the same edge.
- R3: After a load, the first two instruction ticks (cyc_en_i high) produce no increment, whatever events occur. Counting resumes with the third tick.
- R4: With src_ext_i = 0 and pre_wdt_i = 1, count_o increases by one at every clock edge where cyc_en_i is high.
- R5: In counter mode, edge_fall_i = 0 counts 0-to-1 transitions of the synchronized source and edge_fall_i = 1 counts 1-to-0 transitions.
- R6: With src_ext_i = 1 and cmp_route_i = 0, the source is cmp_i, regardless of pin_keep_i. Activity on pin_i has no effect on count_o.
- R7: With src_ext_i = 1 and cmp_route_i = 1, the source is pin_i when pin_keep_i = 1 and cmp_i when pin_keep_i = 0.
- R8: With pre_wdt_i = 0, the counter increments once per 2^(ps_i+1) qualified events.
- R9: With pre_wdt_i = 1, wdt_tick_o pulses once per 2^(ps_i+1) pulses of wdt_tick_i. With pre_wdt_i = 0, wdt_tick_o follows wdt_tick_i undivided.
- R10: A source level present before instruction tick k shows in count_o right after tick k+2 (two stages of synchronization latency).
- R11: A load clears the prescaler count. After it, a full 2^(ps_i+1) events are needed for the next increment.
- R12: The count wraps from 0xFF to 0x00. ovf_o is high for exactly the one clock following that wrap, and never after a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Instruction-cycle tick enable |
| pin_i | input | 1 | External event pin |
| cmp_i | input | 1 | Comparator output |
| src_ext_i | input | 1 | 0: timer mode, 1: counter mode |
| edge_fall_i | input | 1 | Counting edge: 0 rising, 1 falling |
| pre_wdt_i | input | 1 | Prescaler owner: 0 counter, 1 watchdog |
| ps_i | input | 3 | Prescale ratio code, ratio 2^(code+1) |
| cmp_route_i | input | 1 | 0: comparator feeds counter internally; 1: through the pin path |
| pin_keep_i | input | 1 | With routing through the pin path: 1 pin drives, 0 comparator drives the pin |
| wr_en_i | input | 1 | Load strobe for the count |
| wr_data_i | input | 8 | Load value |
| wdt_tick_i | input | 1 | Watchdog base tick |
| count_o | output | 8 | Current count |
| ovf_o | output | 1 | One-clock pulse after wrap |
| wdt_tick_o | output | 1 | Tick delivered to the watchdog |

## Verification
The bench builds the block with its default widths: an 8-bit count, a 3-bit ratio code and a two-stage synchronizer. With these widths every ratio from 1:2 to 1:256 can be swept in a few thousand clocks. A wrap can also be forced quickly by loading values near 0xFF. The behavioural model compares the outputs on every clock through each routing combination, both edge polarities and both prescaler owners. This places the two-tick load holdoff and the synchronizer latency at exact cycles.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    SRC_TICK = 2'd0,
    SRC_CMP  = 2'd1,
    SRC_PIN  = 2'd2
  } src_sel_e;

  function automatic src_sel_e decode_src(logic ext, logic route, logic keep);
    if (!ext)        return SRC_TICK;
    else if (!route) return SRC_CMP;
    else if (keep)   return SRC_PIN;
    else             return SRC_CMP; // comparator driven onto pin, read back
  endfunction
endpackage

// File: rtl/evt_src_sync.sv
module evt_src_sync
  import evt_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  src_sel_e src_sel_i,
  input  logic     pin_i,
  input  logic     cmp_i,
  input  logic     fall_i,
  output logic     evt_o
);
  logic                 raw;
  logic [SYNC_STAGES:0] sh_q;
  logic                 cur, prv, edge_hit;

  always_comb raw = (src_sel_i == SRC_PIN) ? pin_i : cmp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (tick_i) sh_q <= {sh_q[SYNC_STAGES-1:0], raw};
  end

  assign cur      = sh_q[SYNC_STAGES-1];
  assign prv      = sh_q[SYNC_STAGES];
  assign edge_hit = fall_i ? (prv & ~cur) : (cur & ~prv);

  always_comb evt_o = tick_i & ((src_sel_i == SRC_TICK) ? 1'b1 : edge_hit);

  // R10: first stage captures the source only on ticks
  p_sample_on_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sh_q));
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int PS_W  = 3,
  parameter int PRE_W = 1 << PS_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            to_wdt_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            tmr_evt_i,
  input  logic            wdt_evt_i,
  output logic            inc_o,
  output logic            wdt_tick_o
);
  logic [PRE_W-1:0] pre_q, mask;
  logic             pre_evt, full;

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (i <= int'(ps_i));
  end

  assign pre_evt = to_wdt_i ? wdt_evt_i : tmr_evt_i;
  assign full    = &(pre_q | ~mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clr_i)   pre_q <= '0;
    else if (pre_evt) pre_q <= pre_q + 1'b1;
  end

  assign inc_o      = to_wdt_i ? tmr_evt_i : (tmr_evt_i & full);
  assign wdt_tick_o = to_wdt_i ? (wdt_evt_i & full) : wdt_evt_i;

  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pre_q == '0);
  p_div_only_evt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!to_wdt_i && inc_o) |-> tmr_evt_i);
endmodule

// File: rtl/evt_count_reg.sv
module evt_count_reg #(
  parameter int CNT_W      = 8,
  parameter int HOLD_TICKS = 2,
  parameter int HOLD_W     = $clog2(HOLD_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [HOLD_W-1:0] hold_q;
  logic              step;

  assign step = inc_i & (hold_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      hold_q <= '0;
      ovf_o  <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      if (wr_i) begin
        cnt_o  <= wr_data_i;
        hold_q <= HOLD_W'(HOLD_TICKS);
      end else begin
        if (tick_i && hold_q != '0) hold_q <= hold_q - 1'b1;
        if (step) begin
          cnt_o <= cnt_o + 1'b1;
          ovf_o <= &cnt_o;
        end
      end
    end
  end

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_o == $past(wr_data_i));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q != '0 && !wr_i) |=> $stable(cnt_o));
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1));
  p_wrap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (cnt_o == '0) && ($past(cnt_o) == '1) && !$past(wr_i));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_en_i,
  input  logic             pin_i,
  input  logic             cmp_i,
  input  logic             src_ext_i,
  input  logic             edge_fall_i,
  input  logic             pre_wdt_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic             cmp_route_i,
  input  logic             pin_keep_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             wdt_tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             wdt_tick_o
);
  localparam int PRE_W = 1 << PS_W;

  src_sel_e src_sel;
  logic     tmr_evt, inc;

  assign src_sel = decode_src(src_ext_i, cmp_route_i, pin_keep_i);

  evt_src_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .tick_i   (cyc_en_i),
    .src_sel_i(src_sel),
    .pin_i, .cmp_i,
    .fall_i   (edge_fall_i),
    .evt_o    (tmr_evt)
  );

  evt_prescaler #(.PS_W(PS_W), .PRE_W(PRE_W)) u_pre (
    .clk_i, .rst_ni,
    .clr_i     (wr_en_i),
    .to_wdt_i  (pre_wdt_i),
    .ps_i,
    .tmr_evt_i (tmr_evt),
    .wdt_evt_i (wdt_tick_i),
    .inc_o     (inc),
    .wdt_tick_o
  );

  evt_count_reg #(.CNT_W(CNT_W), .HOLD_TICKS(HOLD_TICKS)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i   (cyc_en_i),
    .inc_i    (inc),
    .wr_i     (wr_en_i),
    .wr_data_i,
    .cnt_o    (count_o),
    .ovf_o
  );
endmodule

// File: tb/evt_timer_test.sv
module evt_timer_test;
  logic       clk = 0, rst_n = 0;
  logic       cyc_en = 0, pin = 0, cmp = 0, src_ext = 0, edge_fall = 0;
  logic       pre_wdt = 1, route = 0, keep = 0, wr_en = 0, wdt_in = 0;
  logic [2:0] ps = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] count;
  logic       ovf, wdt_out;

  int checks = 0, failures = 0, ovf_seen = 0;
  bit wdt_run = 0, done = 0;
  string tag = "R1";

  // reference model state
  int m_cnt = 0, m_hold = 0, m_pre = 0, m_ovf = 0;
  int s1 = 0, s2 = 0, s3 = 0;

  evt_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_en_i(cyc_en), .pin_i(pin), .cmp_i(cmp),
    .src_ext_i(src_ext), .edge_fall_i(edge_fall), .pre_wdt_i(pre_wdt), .ps_i(ps),
    .cmp_route_i(route), .pin_keep_i(keep), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wdt_tick_i(wdt_in), .count_o(count), .ovf_o(ovf), .wdt_tick_o(wdt_out)
  );

  initial forever #2 clk = ~clk;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // instruction tick: one clock in four
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      cyc_en = (ph == 3);
      ph = (ph + 1) % 4;
    end
  end

  // watchdog base tick: every third clock when enabled
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      wdt_in = wdt_run && (ph == 0);
      ph = (ph + 1) % 3;
    end
  end

  function automatic int div_now();
    return 2 << ps;
  endfunction

  // behavioural reference, updated at each edge from values held since last drive
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_hold = 0; m_pre = 0; m_ovf = 0; s1 = 0; s2 = 0; s3 = 0;
    end else begin
      int src, edge_ok, tmr_evt, pre_evt, full, inc;
      src = (src_ext && route && keep) ? int'(pin) : int'(cmp);
      edge_ok = edge_fall ? (s3 == 1 && s2 == 0) : (s2 == 1 && s3 == 0);
      tmr_evt = src_ext ? (cyc_en && edge_ok) : int'(cyc_en);
      pre_evt = pre_wdt ? int'(wdt_in) : tmr_evt;
      full = (m_pre % div_now()) == div_now() - 1;
      inc = pre_wdt ? tmr_evt : (tmr_evt && full);
      if (cyc_en) begin s3 = s2; s2 = s1; s1 = src; end
      m_ovf = 0;
      if (wr_en) begin
        m_cnt = wr_data; m_hold = 2; m_pre = 0;
      end else begin
        if (pre_evt) m_pre = (m_pre + 1) % 256;
        if (inc && m_hold == 0) begin
          if (m_cnt == 255) m_ovf = 1;
          m_cnt = (m_cnt + 1) % 256;
        end
        if (cyc_en && m_hold > 0) m_hold--;
      end
    end
  end

  // compare every clock, away from the edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        int full, wexp;
        full = (m_pre % div_now()) == div_now() - 1;
        wexp = pre_wdt ? (wdt_in && full) : int'(wdt_in);
        check(tag, count, m_cnt, "count_o");
        check(tag, ovf, m_ovf, "ovf_o");
        check(pre_wdt ? "R9" : tag, wdt_out, wexp, "wdt_tick_o");
        if (ovf) ovf_seen++;
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(int v);
    @(posedge clk); #1;
    wr_en = 1; wr_data = v[7:0];
    @(negedge clk); @(negedge clk);
    check("R2", count, v, "count_o after load");
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic toggle_src(bit use_pin, int gap, int n);
    for (int i = 0; i < n; i++) begin
      step(gap);
      if (use_pin) pin = ~pin; else cmp = ~cmp;
    end
  endtask

  initial begin
    step(3);
    @(negedge clk);
    check("R1", count, 0, "count_o reset");
    check("R1", ovf, 0, "ovf_o reset");
    rst_n = 1;

    tag = "R4"; step(60);
    tag = "R3"; load(8'h10); step(30); load(8'h20); step(5);
    tag = "R12"; load(8'hFD); step(40);
    check("R12", ovf_seen > 0, 1, "overflow pulse seen");

    tag = "R8"; pre_wdt = 0;
    for (int k = 0; k < 8; k++) begin
      ps = k[2:0]; load(0); step((2 << k) * 4 * 3 + 8);
    end

    tag = "R5"; pre_wdt = 1; src_ext = 1; route = 1; keep = 1;
    edge_fall = 0; toggle_src(1, 13, 10);
    edge_fall = 1; toggle_src(1, 11, 10);
    tag = "R10"; edge_fall = 0; toggle_src(1, 4, 8); toggle_src(1, 9, 8);

    tag = "R6"; route = 0; keep = 1; toggle_src(0, 10, 8); toggle_src(1, 7, 8);
    keep = 0; toggle_src(0, 10, 8); toggle_src(1, 7, 8);

    tag = "R7"; route = 1; keep = 0; toggle_src(0, 9, 8); toggle_src(1, 9, 8);
    keep = 1; toggle_src(1, 9, 8); toggle_src(0, 9, 8);

    tag = "R9"; src_ext = 0; wdt_run = 1;
    for (int k = 0; k < 4; k++) begin ps = k[2:0]; step(80); end
    pre_wdt = 0; step(40); wdt_run = 0;

    tag = "R11"; pre_wdt = 0; ps = 2;
    for (int k = 0; k < 6; k++) begin step(23 + k * 7); load(k * 40); end
    step(100);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule